// File: doc/BRIEF.md
# Pixel Output Formatter with Test Patterns

This block takes the converter's internal sample stream and presents it on a 10-bit parallel output bus after a fixed latency. A 2-bit mode input selects what the bus shows. It can show the delayed samples. It can show one of two fixed words whose bits alternate, which lets a board-level test find stuck or shorted data lines. It can also release the bus by dropping the output enable. The mode acts on the output register only, so the delay line behind it keeps shifting in every mode. When normal output resumes, the bus shows correctly aligned data straight away.

The block also conditions the timing strobes that arrive from outside. The two sample strobes share one polarity setting. The optical-black clamp, the dummy clamp and the blanking strobe share a second polarity setting. All strobes leave the block active-high. When the dummy clamp and blanking are active together, the dummy clamp wins and blanking is masked. A width monitor watches the optical-black clamp and pulses a flag when a pulse ends before it has lasted the minimum number of cycles.

Top module: `pix_out_fmt`

## Requirements
- R1: In mode 00, the value of `sample_in` captured at rising edge k is driven on `data_out` right after rising edge k+9, with `data_oe` high.
- R2: In mode 01, `data_out` shows the word 0101010101 (bit 9 down to bit 0, value 0x155) and `data_oe` is high.
- R3: In mode 10, `data_out` shows the word 1010101010 (bit 9 down to bit 0, value 0x2AA) and `data_oe` is high.
- R4: In mode 11, `data_oe` is low and `data_out` is all zeros. The delay line keeps shifting, so the first normal-mode outputs after a return from mode 11 are the samples captured 9 edges earlier.
- R5: The mode sampled at a rising edge governs the bus value driven right after that same edge.
- R6: The sample-strobe polarity bit (0 = active-low, 1 = active-high) is registered at each edge and applies from the following cycle. `ref_smp_act` and `dat_smp_act` are active-high versions of the raw strobes.
- R7: The clamp-group polarity bit (0 = active-low, 1 = active-high) is registered the same way. It applies to the optical-black clamp, the dummy clamp and blanking, and all three outputs are active-high.
- R8: While the dummy clamp is active, `blank_act` is low whatever the blanking strobe does.
- R9: `ob_short` pulses high for exactly one cycle, right after the first edge at which the optical-black clamp is sampled inactive, when the run of active samples just ended is shorter than 10 edges. A run of 10 or more edges raises no flag.
- R10: A synchronous reset clears the delay line to zero, selects normal output (`data_out` = 0, `data_oe` = 1), sets both polarity registers to active-low and clears `ob_short`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_in | input | 10 | Converter sample |
| out_mode | input | 2 | 00 normal, 01 pattern A, 10 pattern B, 11 bus released |
| sclk_pol | input | 1 | Sample-strobe polarity, 1 = active-high |
| clamp_pol | input | 1 | Clamp and blanking polarity, 1 = active-high |
| ref_smp_raw | input | 1 | Raw reference-level sample strobe |
| dat_smp_raw | input | 1 | Raw data-level sample strobe |
| ob_clamp_raw | input | 1 | Raw optical-black clamp strobe |
| dummy_clamp_raw | input | 1 | Raw dummy-pixel clamp strobe |
| blank_raw | input | 1 | Raw pixel-blanking strobe |
| data_out | output | 10 | Output bus data |
| data_oe | output | 1 | Output bus enable |
| ref_smp_act | output | 1 | Normalized reference sample strobe |
| dat_smp_act | output | 1 | Normalized data sample strobe |
| ob_clamp_act | output | 1 | Normalized optical-black clamp |
| dummy_clamp_act | output | 1 | Normalized dummy clamp |
| blank_act | output | 1 | Normalized blanking, masked by the dummy clamp |
| ob_short | output | 1 | One-cycle flag for a too-short optical-black clamp pulse |

## Verification
Two of the block's functions can land in the same cycle. The dummy clamp and blanking can be active together. In addition, a mode change can happen while the delay line is still refilling after the bus was released. Both are provoked with random strobe and mode traffic under each polarity setting. The overlap is judged by requiring `blank_act` low whenever the normalized dummy clamp is high. After each return from mode 11, the bus is compared sample by sample against a queue-based model that never stopped shifting.

// File: rtl/pof_pkg.sv
package pof_pkg;

    typedef enum logic [1:0] {
        OM_PASS  = 2'b00,
        OM_PAT_A = 2'b01,
        OM_PAT_B = 2'b10,
        OM_HIZ   = 2'b11
    } out_mode_e;

    typedef struct packed {
        logic ref_smp;
        logic dat_smp;
        logic ob_clamp;
        logic dummy_clamp;
        logic blank;
    } strobe_t;

    // Alternating word: bit 0 takes lsb_val, neighbours differ.
    function automatic logic [31:0] alt_word(input int unsigned width, input logic lsb_val);
        logic [31:0] w;
        w = '0;
        for (int unsigned i = 0; i < 32; i++) begin
            if (i < width) w[i] = ((i % 2) == 0) ? lsb_val : ~lsb_val;
        end
        return w;
    endfunction

    function automatic logic to_active_high(input logic raw, input logic pol_high);
        return pol_high ? raw : ~raw;
    endfunction

endpackage

// File: rtl/pof_delay_line.sv
module pof_delay_line #(
    parameter int W     = 10,
    parameter int DEPTH = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) stage[0] <= '0;
                    else     stage[0] <= din;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) stage[g] <= '0;
                    else     stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign dout = stage[DEPTH-1];
endmodule

// File: rtl/pof_out_stage.sv
module pof_out_stage
    import pof_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   mode_in,
    input  logic [W-1:0] din,
    output logic [W-1:0] data_out,
    output logic         data_oe
);
    localparam logic [W-1:0] WORD_A = W'(alt_word(W, 1'b1));
    localparam logic [W-1:0] WORD_B = W'(alt_word(W, 1'b0));

    out_mode_e mode;
    assign mode = out_mode_e'(mode_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_out <= '0;
            data_oe  <= 1'b1;
        end else begin
            unique case (mode)
                OM_PASS:  begin data_out <= din;    data_oe <= 1'b1; end
                OM_PAT_A: begin data_out <= WORD_A; data_oe <= 1'b1; end
                OM_PAT_B: begin data_out <= WORD_B; data_oe <= 1'b1; end
                default:  begin data_out <= '0;     data_oe <= 1'b0; end
            endcase
        end
    end
endmodule

// File: rtl/pof_strobe_norm.sv
module pof_strobe_norm
    import pof_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sclk_pol,
    input  logic    clamp_pol,
    input  strobe_t raw,
    output strobe_t act
);
    logic sclk_pol_q;
    logic clamp_pol_q;
    logic dummy_n;
    logic blank_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_pol_q  <= 1'b0;
            clamp_pol_q <= 1'b0;
        end else begin
            sclk_pol_q  <= sclk_pol;
            clamp_pol_q <= clamp_pol;
        end
    end

    assign dummy_n = to_active_high(raw.dummy_clamp, clamp_pol_q);
    assign blank_n = to_active_high(raw.blank, clamp_pol_q);

    always_comb begin
        act.ref_smp     = to_active_high(raw.ref_smp, sclk_pol_q);
        act.dat_smp     = to_active_high(raw.dat_smp, sclk_pol_q);
        act.ob_clamp    = to_active_high(raw.ob_clamp, clamp_pol_q);
        act.dummy_clamp = dummy_n;
        act.blank       = blank_n & ~dummy_n;
    end
endmodule

// File: rtl/pof_ob_width.sv
module pof_ob_width #(
    parameter int MIN_W = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic ob_act,
    output logic short_flag
);
    localparam int CW = $clog2(MIN_W + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_W);

    logic [CW-1:0] run_len;
    logic          was_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len    <= '0;
            was_active <= 1'b0;
            short_flag <= 1'b0;
        end else if (ob_act) begin
            if (run_len < LIMIT) run_len <= run_len + 1'b1;
            was_active <= 1'b1;
            short_flag <= 1'b0;
        end else begin
            short_flag <= was_active && (run_len < LIMIT);
            run_len    <= '0;
            was_active <= 1'b0;
        end
    end
endmodule

// File: rtl/pix_out_fmt.sv
module pix_out_fmt
    import pof_pkg::*;
#(
    parameter int W       = 10,
    parameter int LATENCY = 9,
    parameter int MIN_OB  = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sample_in,
    input  logic [1:0]   out_mode,
    input  logic         sclk_pol,
    input  logic         clamp_pol,
    input  logic         ref_smp_raw,
    input  logic         dat_smp_raw,
    input  logic         ob_clamp_raw,
    input  logic         dummy_clamp_raw,
    input  logic         blank_raw,
    output logic [W-1:0] data_out,
    output logic         data_oe,
    output logic         ref_smp_act,
    output logic         dat_smp_act,
    output logic         ob_clamp_act,
    output logic         dummy_clamp_act,
    output logic         blank_act,
    output logic         ob_short
);
    // The output register adds one edge, so the line holds LATENCY-0 stages
    // and the sample is read from its last stage at edge k+LATENCY.
    localparam int LINE_DEPTH = LATENCY;

    logic [W-1:0] delayed;
    strobe_t      raw_s;
    strobe_t      act_s;

    pof_delay_line #(.W(W), .DEPTH(LINE_DEPTH)) u_line (
        .clk  (clk),
        .rst  (rst),
        .din  (sample_in),
        .dout (delayed)
    );

    pof_out_stage #(.W(W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .mode_in  (out_mode),
        .din      (delayed),
        .data_out (data_out),
        .data_oe  (data_oe)
    );

    assign raw_s = '{ref_smp: ref_smp_raw, dat_smp: dat_smp_raw, ob_clamp: ob_clamp_raw,
                     dummy_clamp: dummy_clamp_raw, blank: blank_raw};

    pof_strobe_norm u_norm (
        .clk       (clk),
        .rst       (rst),
        .sclk_pol  (sclk_pol),
        .clamp_pol (clamp_pol),
        .raw       (raw_s),
        .act       (act_s)
    );

    assign ref_smp_act     = act_s.ref_smp;
    assign dat_smp_act     = act_s.dat_smp;
    assign ob_clamp_act    = act_s.ob_clamp;
    assign dummy_clamp_act = act_s.dummy_clamp;
    assign blank_act       = act_s.blank;

    pof_ob_width #(.MIN_W(MIN_OB)) u_obw (
        .clk        (clk),
        .rst        (rst),
        .ob_act     (act_s.ob_clamp),
        .short_flag (ob_short)
    );
endmodule

// File: rtl/pix_out_fmt_chk.sv
module pix_out_fmt_chk #(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   out_mode,
    input logic         sclk_pol,
    input logic         clamp_pol,
    input logic         ref_smp_raw,
    input logic         dat_smp_raw,
    input logic         ob_clamp_raw,
    input logic [W-1:0] data_out,
    input logic         data_oe,
    input logic         ref_smp_act,
    input logic         dat_smp_act,
    input logic         ob_clamp_act,
    input logic         dummy_clamp_act,
    input logic         blank_act,
    input logic         ob_short
);
    localparam logic [W-1:0] EXP_A = W'(10'h155);
    localparam logic [W-1:0] EXP_B = W'(10'h2AA);

    AST_RESET_STATE: assert property (@(posedge clk) rst |=> (data_out == '0 && data_oe && !ob_short)) // R10
        else $error("reset state");
    AST_PATTERN_A: assert property (@(posedge clk) disable iff (rst) (out_mode == 2'b01) |=> (data_oe && data_out == EXP_A)) // R2
        else $error("pattern A");
    AST_PATTERN_B: assert property (@(posedge clk) disable iff (rst) (out_mode == 2'b10) |=> (data_oe && data_out == EXP_B)) // R3
        else $error("pattern B");
    AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (rst) (out_mode == 2'b11) |=> (!data_oe && data_out == '0)) // R4
        else $error("bus release");
    AST_BLANK_YIELDS: assert property (@(posedge clk) disable iff (rst) dummy_clamp_act |-> !blank_act) // R8
        else $error("blank priority");
    AST_SHORT_SINGLE: assert property (@(posedge clk) disable iff (rst) ob_short |=> !ob_short) // R9
        else $error("short flag width");
    AST_SHORT_AT_END: assert property (@(posedge clk) disable iff (rst) ob_short |-> !$past(ob_clamp_act)) // R9
        else $error("short flag timing");
    AST_SMP_POL_LOW: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(sclk_pol)) |-> (ref_smp_act == !ref_smp_raw && dat_smp_act == !dat_smp_raw)) // R6
        else $error("sample polarity");
    AST_CLAMP_POL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(clamp_pol)) |-> (ob_clamp_act == ob_clamp_raw)) // R7
        else $error("clamp polarity");
endmodule

bind pix_out_fmt pix_out_fmt_chk #(.W(W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .out_mode        (out_mode),
    .sclk_pol        (sclk_pol),
    .clamp_pol       (clamp_pol),
    .ref_smp_raw     (ref_smp_raw),
    .dat_smp_raw     (dat_smp_raw),
    .ob_clamp_raw    (ob_clamp_raw),
    .data_out        (data_out),
    .data_oe         (data_oe),
    .ref_smp_act     (ref_smp_act),
    .dat_smp_act     (dat_smp_act),
    .ob_clamp_act    (ob_clamp_act),
    .dummy_clamp_act (dummy_clamp_act),
    .blank_act       (blank_act),
    .ob_short        (ob_short)
);

// File: tb/pix_out_fmt_test.sv
`timescale 1ns/1ps
module pix_out_fmt_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] sample_in = '0;
    logic [1:0] out_mode = 2'b00;
    logic       sclk_pol = 1'b0, clamp_pol = 1'b0;
    logic       ref_smp_raw = 1'b0, dat_smp_raw = 1'b0, ob_clamp_raw = 1'b1;
    logic       dummy_clamp_raw = 1'b1, blank_raw = 1'b1;
    logic [9:0] data_out;
    logic       data_oe, ref_smp_act, dat_smp_act, ob_clamp_act;
    logic       dummy_clamp_act, blank_act, ob_short;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pix_out_fmt uut (
        .clk(clk), .rst(rst), .sample_in(sample_in), .out_mode(out_mode),
        .sclk_pol(sclk_pol), .clamp_pol(clamp_pol),
        .ref_smp_raw(ref_smp_raw), .dat_smp_raw(dat_smp_raw), .ob_clamp_raw(ob_clamp_raw),
        .dummy_clamp_raw(dummy_clamp_raw), .blank_raw(blank_raw),
        .data_out(data_out), .data_oe(data_oe),
        .ref_smp_act(ref_smp_act), .dat_smp_act(dat_smp_act), .ob_clamp_act(ob_clamp_act),
        .dummy_clamp_act(dummy_clamp_act), .blank_act(blank_act), .ob_short(ob_short)
    );

    // ---------------- behavioural reference model ----------------
    int  pipe[$];
    int  m_out = 0;
    bit  m_oe = 1;
    bit  m_spol = 0, m_cpol = 0;
    int  ob_run = 0;
    bit  ob_prev = 0;
    bit  m_flag = 0;
    bit  started = 0;
    bit  last_rst = 0;
    int  last_mode = 0;
    int  prev_mode = 0;
    int  since_hiz = 100;

    always @(posedge clk) begin
        bit obn;
        started = 1;
        last_rst = rst;
        prev_mode = last_mode;
        last_mode = out_mode;
        if (rst) begin
            pipe.delete();
            for (int i = 0; i < 9; i++) pipe.push_back(0);
            m_out = 0; m_oe = 1; m_spol = 0; m_cpol = 0;
            ob_run = 0; ob_prev = 0; m_flag = 0;
            since_hiz = 100;
        end else begin
            obn = m_cpol ? ob_clamp_raw : !ob_clamp_raw;
            if (obn) begin
                if (ob_run < 10) ob_run++;
                ob_prev = 1; m_flag = 0;
            end else begin
                m_flag = ob_prev && (ob_run < 10);
                ob_run = 0; ob_prev = 0;
            end
            case (out_mode)
                2'b00: begin m_out = pipe[8]; m_oe = 1; end
                2'b01: begin m_out = 'h155;   m_oe = 1; end
                2'b10: begin m_out = 'h2AA;   m_oe = 1; end
                default: begin m_out = 0;     m_oe = 0; end
            endcase
            if (out_mode == 2'b11) since_hiz = 0;
            else if (since_hiz < 100) since_hiz++;
            pipe.push_front(int'(sample_in));
            void'(pipe.pop_back());
            m_spol = sclk_pol;
            m_cpol = clamp_pol;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            string dtag;
            bit e_ref, e_dat, e_ob, e_dm, e_bl_raw, e_bl;
            if (last_rst) dtag = "R10";
            else if (last_mode == 1) dtag = "R2";
            else if (last_mode == 2) dtag = "R3";
            else if (last_mode == 3) dtag = "R4";
            else if (since_hiz < 10) dtag = "R4";
            else if (prev_mode != last_mode) dtag = "R5";
            else dtag = "R1";
            check(data_out == 10'(m_out), {dtag, " data"}, data_out, m_out);
            check(data_oe == m_oe, {dtag, " enable"}, data_oe, m_oe);
            e_ref = m_spol ? ref_smp_raw : !ref_smp_raw;
            e_dat = m_spol ? dat_smp_raw : !dat_smp_raw;
            e_ob  = m_cpol ? ob_clamp_raw : !ob_clamp_raw;
            e_dm  = m_cpol ? dummy_clamp_raw : !dummy_clamp_raw;
            e_bl_raw = m_cpol ? blank_raw : !blank_raw;
            e_bl  = e_bl_raw && !e_dm;
            check(ref_smp_act == e_ref, "R6 ref strobe", ref_smp_act, e_ref);
            check(dat_smp_act == e_dat, "R6 data strobe", dat_smp_act, e_dat);
            check(ob_clamp_act == e_ob, "R7 ob clamp", ob_clamp_act, e_ob);
            check(dummy_clamp_act == e_dm, "R7 dummy clamp", dummy_clamp_act, e_dm);
            if (e_dm && e_bl_raw) check(blank_act == e_bl, "R8 blank masked", blank_act, e_bl);
            else check(blank_act == e_bl, "R7 blank", blank_act, e_bl);
            check(ob_short == m_flag, last_rst ? "R10 flag" : "R9 short flag", ob_short, m_flag);
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc();
        @(negedge clk);
        #1;
    endtask

    task automatic rand_strobes();
        ref_smp_raw = 1'($urandom); dat_smp_raw = 1'($urandom);
        ob_clamp_raw = 1'($urandom); dummy_clamp_raw = 1'($urandom);
        blank_raw = 1'($urandom);
    endtask

    task automatic ob_pulse(input int width);
        for (int i = 0; i < width; i++) begin
            ob_clamp_raw = clamp_pol;
            sample_in = 10'($urandom);
            cyc();
        end
        for (int i = 0; i < 4; i++) begin
            ob_clamp_raw = !clamp_pol;
            cyc();
        end
    endtask

    initial begin : main
        for (int i = 0; i < 3; i++) cyc();
        rst = 0;
        // R1 normal pass-through
        for (int i = 0; i < 25; i++) begin sample_in = 10'($urandom); rand_strobes(); cyc(); end
        // R2, R3, R4 fixed modes, line keeps filling
        out_mode = 2'b01;
        for (int i = 0; i < 5; i++) begin sample_in = 10'($urandom); cyc(); end
        out_mode = 2'b10;
        for (int i = 0; i < 5; i++) begin sample_in = 10'($urandom); cyc(); end
        out_mode = 2'b11;
        for (int i = 0; i < 12; i++) begin sample_in = 10'($urandom); cyc(); end
        out_mode = 2'b00;
        for (int i = 0; i < 15; i++) begin sample_in = 10'($urandom); cyc(); end
        // R5 mode changes every few cycles
        for (int i = 0; i < 60; i++) begin
            sample_in = 10'($urandom);
            if ((i % 3) == 0) out_mode = 2'($urandom);
            rand_strobes();
            cyc();
        end
        out_mode = 2'b00;
        // R9 short-pulse flag, both polarities
        ob_clamp_raw = !clamp_pol; cyc(); cyc();
        ob_pulse(3); ob_pulse(9); ob_pulse(10); ob_pulse(14); ob_pulse(1);
        clamp_pol = 1; ob_clamp_raw = 0; cyc(); cyc();
        ob_pulse(3); ob_pulse(9); ob_pulse(10); ob_pulse(12);
        // R7, R8 overlap of dummy clamp and blanking under both polarities
        for (int i = 0; i < 25; i++) begin rand_strobes(); cyc(); end
        clamp_pol = 0;
        for (int i = 0; i < 25; i++) begin rand_strobes(); cyc(); end
        // R6 sample-strobe polarity flips
        for (int i = 0; i < 25; i++) begin
            if ((i % 4) == 0) sclk_pol = !sclk_pol;
            rand_strobes(); cyc();
        end
        // R10 reset in the middle of traffic
        out_mode = 2'b11; sclk_pol = 1; clamp_pol = 1;
        cyc(); cyc();
        rst = 1; cyc(); cyc();
        rst = 0; out_mode = 2'b00;
        for (int i = 0; i < 14; i++) begin sample_in = 10'($urandom); rand_strobes(); cyc(); end
        cyc();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule